// File: doc/BRIEF.md
# Memory Bit Invert Read-Modify-Write Unit

The unit inverts one bit of a byte held in memory. It accepts a request that gives a 32-bit base value and either a 16-bit displacement with a 3-bit bit number, or a second register whose low three bits give the bit number. It computes the byte address, reads the byte, writes it back with the chosen bit inverted, and sets a zero flag to the complement of the bit's value before the change.

The memory side is a simple byte port with an address, a read strobe, a write strobe, write data, read data and a shared ready. The read and the write of one operation run back to back with no other access between them. With no wait states, the unit spends one cycle reading, one cycle writing and one cycle signalling completion. The zero flag is the only flag the unit produces. Nothing else is updated.

Top module: `bit_flip_rmw`

## Requirements
- R1: With `req_form`=0, the byte address is `base_val` plus `disp_val` sign-extended from 16 to 32 bits, wrapping modulo 2^32.
- R2: With `req_form`=1, the byte address is `base_val` unchanged and the bit number is `bit_reg[2:0]`. Bits 31:3 of `bit_reg` have no effect.
- R3: With `req_form`=0, the bit number is `bit_imm`, where value k selects bit k of the byte (0 = LSB, 7 = MSB).
- R4: The byte written back equals the byte read, with only the selected bit inverted. It is written to the same address that was read.
- R5: `z_flag` takes the complement of the selected bit as read. It changes only at the edge that raises `done` and otherwise holds its value. It resets to 0.
- R6: With `mem_ready` held high, `done` is high in the third cycle after the edge that accepts the request. Each wait cycle on the read or on the write adds one cycle.
- R7: While a strobe is high and `mem_ready` is low, that strobe stays high. `mem_addr` and `mem_wdata` stay stable during that time.
- R8: Both strobes are low whenever `busy` is low, the two strobes are never high together, and each operation makes exactly one read followed by one write.
- R9: A request is accepted only when the unit is idle (`busy` low). A request raised while `busy` is high produces no memory access and no `done`.
- R10: `done` is a single-cycle pulse, and `busy` is high from the cycle after acceptance through the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start request, sampled while idle |
| req_form | input | 1 | 0 = base plus displacement, 1 = register indirect |
| base_val | input | 32 | Base register value |
| disp_val | input | 16 | Signed displacement |
| bit_imm | input | 3 | Bit number for the displacement form |
| bit_reg | input | 32 | Bit-number register for the indirect form |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| z_flag | output | 1 | Zero flag |
| mem_addr | output | 32 | Byte address |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid with ready |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_ready | input | 1 | Access completes at this edge |

## Verification
The bench targets several corner cases:
- A negative displacement that wraps below the base. Treating it as unsigned would put the access 64 KiB too high.
- The LSB and the MSB as the selected bit. A wrong index would flip a neighbouring bit or pass the byte through.
- A bit-number register with its upper bits set. Decoding more than three bits would pick a wrong or missing bit.
- Flipping the same bit twice, to show that the flag follows the value read and does not simply toggle.
- Wait states on both phases, to catch a sequencer that advances without `ready`.
- A second request raised mid-operation, which an over-eager acceptor would turn into an extra read and write.

// File: rtl/bfr_pkg.sv
package bfr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_DONE  = 2'd3
   } bfr_state_e;

   typedef enum logic {
      FORM_DISP   = 1'b0,
      FORM_REGIND = 1'b1
   } bfr_form_e;
endpackage

// File: rtl/bfr_ea_calc.sv
module bfr_ea_calc #(
   parameter int ADDR_W = 32,
   parameter int DISP_W = 16,
   parameter int BREG_W = 32,
   parameter int BIT_W  = 3
) (
   input  logic              form,
   input  logic [ADDR_W-1:0] base,
   input  logic [DISP_W-1:0] disp,
   input  logic [BIT_W-1:0]  bit_imm,
   input  logic [BREG_W-1:0] bit_reg,
   output logic [ADDR_W-1:0] ea,
   output logic [BIT_W-1:0]  bit_sel
);
   import bfr_pkg::*;

   logic [ADDR_W-1:0] disp_ext;

   generate
      if (BREG_W < BIT_W) begin : g_bad_breg
         $error("bfr_ea_calc: BREG_W narrower than BIT_W");
      end
      if (DISP_W < ADDR_W) begin : g_sext
         assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
      end else begin : g_trunc
         assign disp_ext = disp[ADDR_W-1:0];
      end
   endgenerate

   always_comb begin
      if (bfr_form_e'(form) == FORM_REGIND) begin
         ea      = base;
         bit_sel = bit_reg[BIT_W-1:0];
      end else begin
         ea      = base + disp_ext;
         bit_sel = bit_imm;
      end
   end
endmodule

// File: rtl/bfr_bit_toggle.sv
module bfr_bit_toggle #(
   parameter int DATA_W = 8,
   parameter int BIT_W  = 3
) (
   input  logic [DATA_W-1:0] byte_in,
   input  logic [BIT_W-1:0]  sel,
   output logic [DATA_W-1:0] byte_out,
   output logic              new_bit
);
   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_lane
         assign byte_out[i] = byte_in[i] ^ (sel == BIT_W'(i));
      end
   endgenerate

   assign new_bit = ~byte_in[sel];
endmodule

// File: rtl/bfr_seq.sv
module bfr_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic mem_ready,
   output logic accept,
   output logic rd_en,
   output logic wr_en,
   output logic rd_fire,
   output logic wr_fire,
   output logic busy,
   output logic done
);
   import bfr_pkg::*;

   bfr_state_e state_q, state_d;

   assign accept  = (state_q == ST_IDLE) && req_valid;
   assign rd_en   = (state_q == ST_READ);
   assign wr_en   = (state_q == ST_WRITE);
   assign rd_fire = rd_en && mem_ready;
   assign wr_fire = wr_en && mem_ready;
   assign busy    = (state_q != ST_IDLE);
   assign done    = (state_q == ST_DONE);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (req_valid) state_d = ST_READ;
         ST_READ:  if (mem_ready) state_d = ST_WRITE;
         ST_WRITE: if (mem_ready) state_d = ST_DONE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/bit_flip_rmw.sv
module bit_flip_rmw #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 8,
   parameter int DISP_W = 16,
   parameter int BREG_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_form,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [DISP_W-1:0] disp_val,
   input  logic [$clog2(DATA_W)-1:0] bit_imm,
   input  logic [BREG_W-1:0] bit_reg,
   output logic              busy,
   output logic              done,
   output logic              z_flag,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready
);
   localparam int BIT_W = $clog2(DATA_W);

   generate
      if (DATA_W < 2 || (1 << BIT_W) != DATA_W) begin : g_bad_data
         $error("bit_flip_rmw: DATA_W must be a power of two >= 2");
      end
   endgenerate

   logic              accept, rd_fire, wr_fire;
   logic [ADDR_W-1:0] ea;
   logic [BIT_W-1:0]  bit_sel;
   logic [ADDR_W-1:0] ea_q;
   logic [BIT_W-1:0]  bit_q;
   logic [DATA_W-1:0] byte_q;
   logic [DATA_W-1:0] byte_new;
   logic              new_bit;
   logic              z_q;

   bfr_ea_calc #(
      .ADDR_W(ADDR_W), .DISP_W(DISP_W), .BREG_W(BREG_W), .BIT_W(BIT_W)
   ) u_ea (
      .form(req_form), .base(base_val), .disp(disp_val),
      .bit_imm(bit_imm), .bit_reg(bit_reg), .ea(ea), .bit_sel(bit_sel)
   );

   bfr_bit_toggle #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_tog (
      .byte_in(byte_q), .sel(bit_q), .byte_out(byte_new), .new_bit(new_bit)
   );

   bfr_seq u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mem_ready(mem_ready),
      .accept(accept), .rd_en(mem_rd), .wr_en(mem_wr),
      .rd_fire(rd_fire), .wr_fire(wr_fire), .busy(busy), .done(done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ea_q   <= '0;
         bit_q  <= '0;
         byte_q <= '0;
         z_q    <= 1'b0;
      end else begin
         if (accept) begin
            ea_q  <= ea;
            bit_q <= bit_sel;
         end
         if (rd_fire) byte_q <= mem_rdata;
         if (wr_fire) z_q    <= new_bit;
      end
   end

   assign mem_addr  = ea_q;
   assign mem_wdata = byte_new;
   assign z_flag    = z_q;
endmodule

// File: rtl/bfr_checker.sv
module bfr_checker #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 8,
   parameter int BIT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              z_flag,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ready,
   input logic [BIT_W-1:0]  bit_q
);
   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_rd && !mem_wr));

   a_r7_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

   a_r7_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

   a_r4_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && mem_ready) |=> (mem_wr && mem_addr == $past(mem_addr)));

   a_r5_flag_value: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && mem_ready) |=> (done && z_flag == $past(mem_wdata[bit_q])));

   a_r5_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(z_flag) |-> done);

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mem_addr));
endmodule

bind bit_flip_rmw bfr_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_W(BIT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .z_flag(z_flag),
   .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
   .mem_wdata(mem_wdata), .mem_ready(mem_ready), .bit_q(bit_q)
);

// File: tb/bit_flip_rmw_bench.sv
`timescale 1ns/1ps
module bit_flip_rmw_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_form = 1'b0;
   logic [31:0] base_val = '0;
   logic [15:0] disp_val = '0;
   logic [2:0]  bit_imm = '0;
   logic [31:0] bit_reg = '0;
   logic        busy, done, z_flag;
   logic [31:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [7:0]  mem_rdata = '0;
   logic [7:0]  mem_wdata;
   logic        mem_ready = 1'b0;

   always #4 clk = ~clk;

   bit_flip_rmw u_bit_flip_rmw (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_form(req_form),
      .base_val(base_val), .disp_val(disp_val), .bit_imm(bit_imm),
      .bit_reg(bit_reg), .busy(busy), .done(done), .z_flag(z_flag),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_ready(mem_ready)
   );

   typedef struct packed {
      logic [31:0] addr;
      logic [7:0]  wdata;
      logic        z;
   } exp_t;

   exp_t        q[$];
   logic [7:0]  mem [256];
   int          n_cmp = 0;
   int          n_bad = 0;
   int          wait_cfg = 0;
   int          wcnt = 0;
   int          n_rd = 0;
   int          n_wr = 0;
   int          n_done = 0;
   bit          finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // memory responder
   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
      forever begin
         @(negedge clk);
         if (mem_rd || mem_wr) begin
            if (wcnt >= wait_cfg) begin
               mem_ready = 1'b1;
               mem_rdata = mem[mem_addr[7:0]];
               wcnt = 0;
            end else begin
               mem_ready = 1'b0;
               wcnt++;
            end
         end else begin
            mem_ready = 1'b0;
            wcnt = 0;
         end
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         if (mem_wr && mem_ready) mem[mem_addr[7:0]] = mem_wdata;
      end
   end

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n) begin
            if (!busy) chk(!mem_rd && !mem_wr, "R8 idle strobes", {30'b0, mem_rd, mem_wr}, 32'h0);
            if (mem_rd && mem_ready) begin
               n_rd++;
               if (q.size() > 0)
                  chk(mem_addr == q[0].addr, "R1/R2 read address", mem_addr, q[0].addr);
            end
            if (mem_wr && mem_ready) begin
               n_wr++;
               if (q.size() > 0) begin
                  chk(mem_addr == q[0].addr, "R4 write address", mem_addr, q[0].addr);
                  chk(mem_wdata == q[0].wdata, "R3/R4 write data", {24'b0, mem_wdata}, {24'b0, q[0].wdata});
               end else chk(1'b0, "R9 unexpected write", mem_addr, 32'h0);
            end
            if (done) begin
               n_done++;
               if (q.size() > 0) begin
                  chk(z_flag == q[0].z, "R5 z flag", {31'b0, z_flag}, {31'b0, q[0].z});
                  void'(q.pop_front());
               end else chk(1'b0, "R9 unexpected done", 32'h1, 32'h0);
            end
         end
      end
   end

   // driver: pushes expectation, issues request, measures latency
   task automatic do_op(input bit form, input logic [31:0] base, input logic [15:0] disp,
                        input logic [2:0] bimm, input logic [31:0] breg, input string tag);
      logic [31:0] a;
      logic [2:0]  b;
      logic [7:0]  old;
      exp_t        e;
      int          cyc;
      a   = form ? base : base + {{16{disp[15]}}, disp};
      b   = form ? breg[2:0] : bimm;
      old = mem[a[7:0]];
      e.addr  = a;
      e.wdata = old ^ (8'h1 << b);
      e.z     = ~old[b];
      q.push_back(e);
      @(negedge clk);
      req_valid = 1'b1; req_form = form; base_val = base;
      disp_val = disp; bit_imm = bimm; bit_reg = breg;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1;
      while (!done && cyc < 50) begin
         @(negedge clk);
         cyc++;
      end
      #2;
      chk(cyc == 3 + 2 * wait_cfg, {"R6 latency ", tag}, 32'(cyc), 32'(3 + 2 * wait_cfg));
      chk(mem[a[7:0]] == e.wdata, {"R4 memory ", tag}, {24'b0, mem[a[7:0]]}, {24'b0, e.wdata});
   endtask

   initial begin
      int rd0, wr0, dn0;
      logic [7:0] other;
      repeat (3) @(negedge clk);
      #1;
      chk(!busy && !done && !z_flag && !mem_rd && !mem_wr, "R5/R10 reset state",
          {27'b0, busy, done, z_flag, mem_rd, mem_wr}, 32'h0);
      rst_n = 1'b1;

      do_op(1'b0, 32'h1000_0010, 16'h0005, 3'd0, 32'h0, "R1 R3 bit0");
      do_op(1'b0, 32'h0000_0100, 16'hFFF0, 3'd7, 32'h0, "R1 negative disp bit7");
      do_op(1'b1, 32'h0000_0020, 16'h1234, 3'd6, 32'hFFFF_FFFA, "R2 upper bits");
      do_op(1'b1, 32'h0000_0020, 16'h0000, 3'd0, 32'h0000_0002, "R5 second flip");

      rd0 = n_rd; wr0 = n_wr; dn0 = n_done;
      wait_cfg = 2;
      do_op(1'b0, 32'h0000_0040, 16'h7FFF, 3'd5, 32'h0, "R7 wait states");
      chk(n_rd - rd0 == 1 && n_wr - wr0 == 1 && n_done - dn0 == 1, "R8 one read one write",
          32'(n_rd - rd0 + n_wr - wr0), 32'd2);

      // R9: second request while busy is ignored
      other = mem[8'h60];
      rd0 = n_rd; dn0 = n_done;
      begin
         exp_t e;
         e.addr = 32'h50; e.wdata = mem[8'h50] ^ 8'h02; e.z = ~mem[8'h50][1];
         q.push_back(e);
      end
      @(negedge clk);
      req_valid = 1'b1; req_form = 1'b1; base_val = 32'h50; bit_reg = 32'h1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk(busy, "R10 busy after accept", {31'b0, busy}, 32'h1);
      req_valid = 1'b1; req_form = 1'b1; base_val = 32'h60; bit_reg = 32'h3;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (20) @(negedge clk);
      #2;
      chk(n_done - dn0 == 1, "R9 single done", 32'(n_done - dn0), 32'd1);
      chk(n_rd - rd0 == 1, "R9 single read", 32'(n_rd - rd0), 32'd1);
      chk(mem[8'h60] == other, "R9 other byte untouched", {24'b0, mem[8'h60]}, {24'b0, other});
      chk(q.size() == 0, "R5 scoreboard drained", 32'(q.size()), 32'd0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule